// File: doc/BRIEF.md
# Width-Expanded Dual-Clock FIFO with Merged Lane Flags

This block builds one wide queue out of several narrower FIFO lanes of equal depth. Each lane carries one slice of the wide word: lane `i` holds bits `[i*LANE_W +: LANE_W]`. Every lane has its own Gray-coded pointers and two-flop pointer synchronizers, or three flops where a lane is parameterised to lag. The write clock, write enable, read clock and read enable are common to all lanes. Clock skew can make one lane release its empty or full condition a cycle after another. The lanes' status outputs are therefore never used alone. They pass through a gate so that the wide queue only moves when every lane can move.

The mode is fixed by the `FWFT` parameter. With `FWFT = 0` (standard mode), `rdFlagN` is an active-low empty and `wrFlagN` is an active-low full. Each composite flag is the AND of the lanes' active-low flags, and read data appears on the cycle after an accepted read. With `FWFT = 1` (first-word-fall-through mode), `rdFlagN` is an active-low output-ready and `wrFlagN` is an active-low input-ready. Each composite flag is the OR of the lanes' flags, and the head word is shown on `rdData` while output-ready is low. Half-full, almost-full and almost-empty are taken from lane 0 alone. The wrapper gates every write and read with the composite flags, so no lane can overflow or underflow and the lane pointers stay in step.

Top module: `wide_lane_fifo`

## Requirements
- R1: Each wide word read out equals, bit for bit and in write order, a wide word that was accepted. No word mixes slices from different writes.
- R2: While `mstRstN` is low, all lanes are cleared. The flags then read as follows. Standard mode: `rdFlagN`=0, `wrFlagN`=1. FWFT mode: `rdFlagN`=1, `wrFlagN`=0. Both modes: `halfFullN`=1, `almostFullN`=1, `almostEmptyN`=0. In standard mode `rdData` is 0.
- R3: In standard mode, `rdFlagN` is the AND of the lanes' active-low empty flags. A read is accepted only when `rdFlagN`=1 at the rising read-clock edge, and the word appears on `rdData` after that edge.
- R4: In standard mode, `wrFlagN` is the AND of the lanes' active-low full flags. The queue holds exactly 2^ADDR_W words, and `wrFlagN` reads 0 when it is full.
- R5: In FWFT mode, `rdFlagN` is the OR of the lanes' active-low output-ready flags. While it is 0, `rdData` holds the oldest word, and a read at that edge consumes the word.
- R6: In FWFT mode, `wrFlagN` is the OR of the lanes' active-low input-ready flags. The queue holds 2^ADDR_W + 1 words (memory plus output register), and `wrFlagN` reads 1 when it is full.
- R7: A write while the composite flag shows the queue cannot accept is ignored. No extra word ever appears at the output.
- R8: A read while the composite flag shows no word is ready is ignored. No word is produced and later words keep their order.
- R9: When one lane's pointer synchronizer has an extra stage (`LANE_EXTRA_SYNC` bit set), R1 still holds in both modes.
- R10: The level flags follow lane 0's memory count. The count excludes the FWFT output register, and each flag uses the count seen in its own clock domain. `halfFullN` is 0 when the write-side count exceeds 2^ADDR_W/2. `almostFullN` is 0 when the write-side count is at least 2^ADDR_W − AF_GAP. `almostEmptyN` is 0 when the read-side count is at most AE_GAP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock shared by all lanes |
| rdClk | input | 1 | Read clock shared by all lanes |
| mstRstN | input | 1 | Asynchronous active-low master reset of all lanes |
| wrEn | input | 1 | Write request, common to all lanes |
| wrData | input | LANES*LANE_W | Wide input word, lane i takes slice i |
| rdEn | input | 1 | Read request, common to all lanes |
| rdData | output | LANES*LANE_W | Wide output word, concatenated lane outputs |
| rdFlagN | output | 1 | Composite empty (standard) or output-ready (FWFT), active low |
| wrFlagN | output | 1 | Composite full (standard) or input-ready (FWFT), active low |
| halfFullN | output | 1 | Half-full from lane 0, active low |
| almostFullN | output | 1 | Almost-full from lane 0, active low |
| almostEmptyN | output | 1 | Almost-empty from lane 0, active low |

## Verification
Two instances, one per mode, are driven with identical enables. In each instance a different lane carries the extra synchronizer stage, so the lanes' flags disagree for a cycle whenever the queue leaves empty or full. A write-only fill followed by a read-only drain pins down each mode's exact capacity, flag polarity and level thresholds. It also exercises enables held against full and against empty. Balanced, write-heavy, read-heavy and back-to-back random traffic then crosses the empty and full edges many times with the two clocks drifting. This separates a correct merge of the lane flags from one that trusts a single lane, which would show up as torn or lost words.

// File: rtl/wlf_pkg.sv
package wlf_pkg;

  // Strobes from the flag-merging control to the lane datapath.
  typedef struct packed {
    logic wrPush;  // write accepted on this wrClk edge
    logic rdPop;   // read accepted on this rdClk edge
  } wlf_strobe_t;

endpackage

// File: rtl/wlf_lanes.sv
module wlf_lanes
  import wlf_pkg::*;
#(
  parameter int              LANES           = 2,
  parameter int              LANE_W          = 36,
  parameter int              ADDR_W          = 4,
  parameter bit              FWFT            = 1'b0,
  parameter logic [LANES-1:0] LANE_EXTRA_SYNC = '0
) (
  input  logic                    wrClk,
  input  logic                    rdClk,
  input  logic                    rstN,
  input  wlf_strobe_t             strobes,
  input  logic [LANES*LANE_W-1:0] wrData,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic [LANES-1:0]        laneEmpty,
  output logic [LANES-1:0]        laneFull,
  output logic [ADDR_W:0]         wrCount0,
  output logic [ADDR_W:0]         rdCount0
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int k = PW - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : gLane
    localparam int STG = LANE_EXTRA_SYNC[i] ? 3 : 2;

    logic [LANE_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wBin, wGray, rBin, rGray;
    logic [PW-1:0]     rSync [STG];
    logic [PW-1:0]     wSync [STG];
    logic [LANE_W-1:0] dataQ;
    logic              outValid, isEmpty, isFull, load;

    // write side
    always_ff @(posedge wrClk or negedge rstN) begin
      if (!rstN) begin
        wBin  <= '0;
        wGray <= '0;
      end else if (strobes.wrPush) begin
        wBin  <= wBin + 1'b1;
        wGray <= bin2gray(wBin + 1'b1);
      end
    end

    always_ff @(posedge wrClk) begin
      if (strobes.wrPush) mem[wBin[ADDR_W-1:0]] <= wrData[i*LANE_W +: LANE_W];
    end

    always_ff @(posedge wrClk or negedge rstN) begin
      if (!rstN) begin
        for (int k = 0; k < STG; k++) rSync[k] <= '0;
      end else begin
        rSync[0] <= rGray;
        for (int k = 1; k < STG; k++) rSync[k] <= rSync[k-1];
      end
    end

    assign isFull = (wGray == {~rSync[STG-1][PW-1:PW-2], rSync[STG-1][PW-3:0]});

    // read side
    always_ff @(posedge rdClk or negedge rstN) begin
      if (!rstN) begin
        for (int k = 0; k < STG; k++) wSync[k] <= '0;
      end else begin
        wSync[0] <= wGray;
        for (int k = 1; k < STG; k++) wSync[k] <= wSync[k-1];
      end
    end

    assign isEmpty = (rGray == wSync[STG-1]);
    assign load    = FWFT ? (!isEmpty && (!outValid || strobes.rdPop)) : strobes.rdPop;

    always_ff @(posedge rdClk or negedge rstN) begin
      if (!rstN) begin
        rBin     <= '0;
        rGray    <= '0;
        dataQ    <= '0;
        outValid <= 1'b0;
      end else begin
        if (load) begin
          rBin  <= rBin + 1'b1;
          rGray <= bin2gray(rBin + 1'b1);
          dataQ <= mem[rBin[ADDR_W-1:0]];
        end
        if (load)               outValid <= 1'b1;
        else if (strobes.rdPop) outValid <= 1'b0;
      end
    end

    assign laneEmpty[i] = FWFT ? !outValid : isEmpty;
    assign laneFull[i]  = isFull;
    assign rdData[i*LANE_W +: LANE_W] = dataQ;

    if (i == 0) begin : gLevels
      assign wrCount0 = wBin - gray2bin(rSync[STG-1]);
      assign rdCount0 = gray2bin(wSync[STG-1]) - rBin;
    end

    // R7: the merged write gate never pushes into a full lane
    assert_no_overflow_R7: assert property (@(posedge wrClk) disable iff (!rstN)
      strobes.wrPush |-> !isFull);

    // R8: the merged read gate never pops a lane with nothing to give
    assert_no_underflow_R8: assert property (@(posedge rdClk) disable iff (!rstN)
      strobes.rdPop |-> (FWFT ? outValid : !isEmpty));
  end

endmodule

// File: rtl/wlf_ctrl.sv
module wlf_ctrl
  import wlf_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int ADDR_W = 4,
  parameter bit FWFT   = 1'b0,
  parameter int AE_GAP = 2,
  parameter int AF_GAP = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [LANES-1:0]  laneEmpty,
  input  logic [LANES-1:0]  laneFull,
  input  logic [ADDR_W:0]   wrCount0,
  input  logic [ADDR_W:0]   rdCount0,
  output wlf_strobe_t       strobes,
  output logic              rdFlagN,
  output logic              wrFlagN,
  output logic              halfFullN,
  output logic              almostFullN,
  output logic              almostEmptyN
);

  localparam int            DEPTH  = 1 << ADDR_W;
  localparam logic [ADDR_W:0] HF_LVL = (ADDR_W+1)'(DEPTH / 2);
  localparam logic [ADDR_W:0] AF_LVL = (ADDR_W+1)'(DEPTH - AF_GAP);
  localparam logic [ADDR_W:0] AE_LVL = (ADDR_W+1)'(AE_GAP);

  logic [LANES-1:0] laneRdN, laneWrN;
  logic             rdOk, wrOk;

  if (FWFT) begin : gFwft
    // per-lane active-low output-ready / input-ready, merged with OR
    assign laneRdN = laneEmpty;
    assign laneWrN = laneFull;
    assign rdFlagN = |laneRdN;
    assign wrFlagN = |laneWrN;
    assign rdOk    = !rdFlagN;
    assign wrOk    = !wrFlagN;
  end else begin : gStd
    // per-lane active-low empty / full, merged with AND
    assign laneRdN = ~laneEmpty;
    assign laneWrN = ~laneFull;
    assign rdFlagN = &laneRdN;
    assign wrFlagN = &laneWrN;
    assign rdOk    = rdFlagN;
    assign wrOk    = wrFlagN;
  end

  always_comb begin
    strobes.wrPush = wrEn && wrOk;
    strobes.rdPop  = rdEn && rdOk;
  end

  assign halfFullN    = !(wrCount0 > HF_LVL);
  assign almostFullN  = !(wrCount0 >= AF_LVL);
  assign almostEmptyN = !(rdCount0 <= AE_LVL);

  // R10: a full lane 0 must already report half-full and almost-full
  assert_full_levels_R10: assert property (@(posedge wrClk) disable iff (!rstN)
    laneFull[0] |-> (!halfFullN && !almostFullN));

  if (!FWFT) begin : gStdChk
    // R10: an empty lane 0 must report almost-empty
    assert_empty_level_R10: assert property (@(posedge rdClk) disable iff (!rstN)
      laneEmpty[0] |-> !almostEmptyN);
  end

endmodule

// File: rtl/wide_lane_fifo.sv
module wide_lane_fifo
  import wlf_pkg::*;
#(
  parameter int               LANES           = 2,
  parameter int               LANE_W          = 36,
  parameter int               ADDR_W          = 4,
  parameter bit               FWFT            = 1'b0,
  parameter logic [LANES-1:0] LANE_EXTRA_SYNC = '0,
  parameter int               AE_GAP          = 2,
  parameter int               AF_GAP          = 2,
  localparam int              DATA_W          = LANES * LANE_W
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mstRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdFlagN,
  output logic              wrFlagN,
  output logic              halfFullN,
  output logic              almostFullN,
  output logic              almostEmptyN
);

  wlf_strobe_t      strobes;
  logic [LANES-1:0] laneEmpty, laneFull;
  logic [ADDR_W:0]  wrCount0, rdCount0;

  wlf_ctrl #(
    .LANES(LANES), .ADDR_W(ADDR_W), .FWFT(FWFT), .AE_GAP(AE_GAP), .AF_GAP(AF_GAP)
  ) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(mstRstN),
    .wrEn(wrEn), .rdEn(rdEn),
    .laneEmpty(laneEmpty), .laneFull(laneFull),
    .wrCount0(wrCount0), .rdCount0(rdCount0),
    .strobes(strobes),
    .rdFlagN(rdFlagN), .wrFlagN(wrFlagN),
    .halfFullN(halfFullN), .almostFullN(almostFullN), .almostEmptyN(almostEmptyN)
  );

  wlf_lanes #(
    .LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .FWFT(FWFT),
    .LANE_EXTRA_SYNC(LANE_EXTRA_SYNC)
  ) uLanes (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(mstRstN),
    .strobes(strobes),
    .wrData(wrData), .rdData(rdData),
    .laneEmpty(laneEmpty), .laneFull(laneFull),
    .wrCount0(wrCount0), .rdCount0(rdCount0)
  );

endmodule

// File: tb/tb_wide_lane_fifo.sv
module tb_wide_lane_fifo;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LANES  = 2;
  localparam int LANE_W = 36;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DW     = LANES * LANE_W;

  typedef logic [DW-1:0] word_t;

  logic    wrClk = 1'b0, rdClk = 1'b0, mstRstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  word_t   wrData = '0;
  word_t   sData, fData;
  logic    sRdN, sWrN, sHf, sAf, sAe;
  logic    fRdN, fWrN, fHf, fAf, fAe;

  int      nRun = 0, nFail = 0;
  bit      done = 1'b0;
  int      wrPct = 0, rdPct = 0;
  word_t   qS[$];
  word_t   qF[$];
  bit      pendS = 1'b0;
  logic [31:0] seq = '0;

  always #4 wrClk = ~wrClk;                      // 125 MHz write clock
  initial begin #1; forever #5 rdClk = ~rdClk; end  // 100 MHz read clock, offset

  // standard mode, lane 1 lags by a synchronizer stage
  wide_lane_fifo #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .FWFT(1'b0),
                   .LANE_EXTRA_SYNC(2'b10)) dut (
    .wrClk(wrClk), .rdClk(rdClk), .mstRstN(mstRstN), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(sData), .rdFlagN(sRdN), .wrFlagN(sWrN),
    .halfFullN(sHf), .almostFullN(sAf), .almostEmptyN(sAe));

  // first-word-fall-through mode, lane 0 lags by a synchronizer stage
  wide_lane_fifo #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .FWFT(1'b1),
                   .LANE_EXTRA_SYNC(2'b01)) dutFw (
    .wrClk(wrClk), .rdClk(rdClk), .mstRstN(mstRstN), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(fData), .rdFlagN(fRdN), .wrFlagN(fWrN),
    .halfFullN(fHf), .almostFullN(fAf), .almostEmptyN(fAe));

  task automatic check(input bit ok, input string req, input word_t act, input word_t exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmpWord(input string req, input word_t act, ref word_t q[$]);
    word_t exp;
    if (q.size() == 0) begin
      check(1'b0, {req, " R8 word produced from empty queue"}, act, '0);
    end else begin
      exp = q.pop_front();
      check(act === exp, req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  // write-side stimulus and reference model (inputs change at falling edge)
  always @(negedge wrClk) begin
    wrEn   = mstRstN && (int'($urandom_range(99)) < wrPct);
    seq    = seq + 32'd1;
    wrData = {4'hC, seq, 4'h3, ~seq};
    if (wrEn && sWrN)  qS.push_back(wrData);   // standard: accepted when not full
    if (wrEn && !fWrN) qF.push_back(wrData);   // FWFT: accepted when input ready
  end

  // read-side stimulus and comparison on every read clock
  always @(negedge rdClk) begin
    if (pendS) begin
      cmpWord("R1 R3 R9 standard word", sData, qS);
      pendS = 1'b0;
    end
    rdEn = mstRstN && (int'($urandom_range(99)) < rdPct);
    if (rdEn && sRdN) pendS = 1'b1;
    if (rdEn && !fRdN) cmpWord("R1 R5 R9 fwft head word", fData, qF);
  end

  task automatic runPhase(input int w, input int r, input int cycles);
    wrPct = w;
    rdPct = r;
    repeat (cycles) @(negedge wrClk);
  endtask

  task automatic drain();
    wrPct = 0;
    rdPct = 100;
    repeat (120) @(negedge rdClk);
    rdPct = 0;
    repeat (4) @(negedge rdClk);
    check(qS.size() == 0, "R1 R7 standard queue fully drained", word_t'(qS.size()), '0);
    check(qF.size() == 0, "R1 R7 fwft queue fully drained", word_t'(qF.size()), '0);
    check(sRdN == 1'b0, "R3 standard empty after drain", word_t'(sRdN), '0);
    check(fRdN == 1'b1, "R5 fwft not ready after drain", word_t'(fRdN), 1);
  endtask

  initial begin
    repeat (4) @(negedge wrClk);
    // R2 reset state
    check(sRdN == 1'b0, "R2 standard empty at reset", word_t'(sRdN), 0);
    check(sWrN == 1'b1, "R2 standard not full at reset", word_t'(sWrN), 1);
    check(fRdN == 1'b1, "R2 fwft not output-ready at reset", word_t'(fRdN), 1);
    check(fWrN == 1'b0, "R2 fwft input-ready at reset", word_t'(fWrN), 0);
    check({sHf, sAf, sAe} == 3'b110, "R2 standard level flags at reset", word_t'({sHf, sAf, sAe}), 6);
    check({fHf, fAf, fAe} == 3'b110, "R2 fwft level flags at reset", word_t'({fHf, fAf, fAe}), 6);
    check(sData == '0, "R2 standard rdData at reset", sData, '0);
    mstRstN = 1'b1;

    // fill with writes only: capacity and full flags (R4, R6, R7)
    runPhase(100, 0, 60);
    wrPct = 0;
    repeat (2) @(negedge wrClk);
    check(qS.size() == DEPTH, "R4 R7 standard capacity", word_t'(qS.size()), word_t'(DEPTH));
    check(qF.size() == DEPTH + 1, "R6 R7 fwft capacity", word_t'(qF.size()), word_t'(DEPTH + 1));
    check(sWrN == 1'b0, "R4 standard full flag", word_t'(sWrN), 0);
    check(fWrN == 1'b1, "R6 fwft input not ready", word_t'(fWrN), 1);
    check({sHf, sAf} == 2'b00, "R10 standard half/almost full", word_t'({sHf, sAf}), 0);
    check({fHf, fAf} == 2'b00, "R10 fwft half/almost full", word_t'({fHf, fAf}), 0);
    repeat (6) @(negedge rdClk);
    check(sAe == 1'b1 && fAe == 1'b1, "R10 almost-empty released when full", word_t'({sAe, fAe}), 3);
    check(sRdN == 1'b1, "R3 standard not empty", word_t'(sRdN), 1);
    check(fRdN == 1'b0, "R5 fwft output ready", word_t'(fRdN), 0);

    // drain, keep reading past empty (R8)
    drain();
    check(sAe == 1'b0 && fAe == 1'b0, "R10 almost-empty after drain", word_t'({sAe, fAe}), 0);
    @(negedge wrClk);
    check(sWrN == 1'b1 && fWrN == 1'b0, "R4 R6 write side free after drain", word_t'({sWrN, fWrN}), 2);
    check(sHf == 1'b1 && sAf == 1'b1, "R10 standard levels after drain", word_t'({sHf, sAf}), 3);

    // mixed traffic patterns crossing empty and full (R1, R7, R8, R9)
    runPhase(50, 50, 2000);
    runPhase(90, 30, 1500);
    runPhase(30, 90, 1500);
    runPhase(100, 100, 1000);
    runPhase(95, 5, 400);
    drain();

    finishRun();
  end

  initial begin
    #1_000_000;
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      finishRun();
    end
  end

endmodule